// File: doc/BRIEF.md
# Relative branch condition unit

This unit decides whether a conditional relative branch of an 8-bit CPU with a 16-bit address space is taken, and produces the program counter to continue from. The decoder supplies a 5-bit condition select code. The flag logic supplies the carry, zero, negative, half-carry and interrupt mask flags. The fetch unit supplies the address that follows the branch instruction and the signed offset byte. The unit also tests the level of an external interrupt request pin. Because that pin is asynchronous to the core clock, it first passes through a two-flop synchronizer.

The condition test and the target add are combinational. When `REG_OUT` is 1, a single register stage is placed after them and outputs change one clock after the inputs. A taken branch adds the sign-extended offset to the follow-on address. A branch that is not taken returns the follow-on address unchanged.

Top module: `rel_branch_unit`

## Requirements
- R1: When taken, `target_o` equals `next_pc_i` plus `offset_i` sign-extended as a two's complement byte. Offset 0x80 gives −128 and offset 0x7F gives +127.
- R2: The offset is added to `next_pc_i`, which is the address after the branch instruction, and not to any earlier address.
- R3: The sum wraps modulo 2^16 at both ends of the address space.
- R4: When not taken, `target_o` equals `next_pc_i`.
- R5: Code 2 (carry clear) and code 10 (higher-or-same) are taken when carry is 0. Code 3 (carry set) and code 11 (lower) are taken when carry is 1.
- R6: Code 4 (not equal) is taken when zero is 0. Code 5 (equal) is taken when zero is 1.
- R7: Code 8 (higher) is taken when carry and zero are both 0. Code 9 (lower-or-same) is taken when carry or zero is 1.
- R8: Code 12 (plus) is taken when negative is 0. Code 13 (minus) is taken when negative is 1.
- R9: Code 6 (half-carry clear) is taken when half-carry is 0. Code 7 (half-carry set) is taken when half-carry is 1.
- R10: Code 14 (mask clear) is taken when the interrupt mask is 0. Code 15 (mask set) is taken when the interrupt mask is 1.
- R11: Code 16 (pin high) and code 17 (pin low) test the interrupt pin after two synchronizer flops. The flops reset to 1, so a pin change is seen after the second rising clock edge.
- R12: Code 1 is always taken. Code 0 is never taken.
- R13: Codes 18 to 31 are never taken.
- R14: With `REG_OUT`=1, `taken_o` and `target_o` are registered one cycle after the inputs and reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cond_sel_i | input | 5 | Branch condition code |
| carry_i | input | 1 | Carry flag |
| zero_i | input | 1 | Zero flag |
| neg_i | input | 1 | Negative flag |
| half_i | input | 1 | Half-carry flag |
| imask_i | input | 1 | Interrupt mask flag |
| irq_pin_i | input | 1 | Asynchronous interrupt request pin level |
| next_pc_i | input | 16 | Address following the branch instruction |
| offset_i | input | 8 | Signed branch offset |
| taken_o | output | 1 | Branch taken |
| target_o | output | 16 | Next program counter |

## Verification
The offsets 0x80 and 0x7F are driven on purpose. A design that zero-extends the offset would jump forward 128 bytes instead of back. Targets that cross 0xFFFF upward and 0x0000 downward expose an adder that saturates or carries into a seventeenth bit. Every condition code is swept over all flag combinations and both pin levels. This catches swapped polarities, a higher test that ignores zero, and unused codes that decode to something taken. Pin toggles are compared against a two-edge delayed model, so a missing or extra synchronizer stage shows up as a one-cycle disagreement.

// File: rtl/rbu_pkg.sv
package rbu_pkg;
  localparam int unsigned CSEL_W = 5;

  typedef enum logic [CSEL_W-1:0] {
    COND_NEVER  = 5'd0,
    COND_ALWAYS = 5'd1,
    COND_CC     = 5'd2,
    COND_CS     = 5'd3,
    COND_NE     = 5'd4,
    COND_EQ     = 5'd5,
    COND_HCC    = 5'd6,
    COND_HCS    = 5'd7,
    COND_HI     = 5'd8,
    COND_LS     = 5'd9,
    COND_HS     = 5'd10,
    COND_LO     = 5'd11,
    COND_PL     = 5'd12,
    COND_MI     = 5'd13,
    COND_MC     = 5'd14,
    COND_MS     = 5'd15,
    COND_PINH   = 5'd16,
    COND_PINL   = 5'd17
  } cond_e;

  localparam logic [CSEL_W-1:0] COND_LAST = 5'd17;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic h;
    logic i;
  } flags_t;
endpackage

// File: rtl/rbu_sync.sv
module rbu_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q[0] <= RESET_VAL;
    else         q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[s] <= RESET_VAL;
      else         q[s] <= q[s-1];
    end
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/rbu_cond.sv
module rbu_cond
  import rbu_pkg::*;
(
  input  logic [CSEL_W-1:0] sel_i,
  input  flags_t            flags_i,
  input  logic              pin_i,
  output logic              take_o
);
  always_comb begin
    case (sel_i)
      COND_NEVER:       take_o = 1'b0;
      COND_ALWAYS:      take_o = 1'b1;
      COND_CC, COND_HS: take_o = ~flags_i.c;
      COND_CS, COND_LO: take_o = flags_i.c;
      COND_NE:          take_o = ~flags_i.z;
      COND_EQ:          take_o = flags_i.z;
      COND_HCC:         take_o = ~flags_i.h;
      COND_HCS:         take_o = flags_i.h;
      COND_HI:          take_o = ~(flags_i.c | flags_i.z);
      COND_LS:          take_o = flags_i.c | flags_i.z;
      COND_PL:          take_o = ~flags_i.n;
      COND_MI:          take_o = flags_i.n;
      COND_MC:          take_o = ~flags_i.i;
      COND_MS:          take_o = flags_i.i;
      COND_PINH:        take_o = pin_i;
      COND_PINL:        take_o = ~pin_i;
      default:          take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rbu_target.sv
module rbu_target #(
  parameter int unsigned AW = 16,
  parameter int unsigned OW = 8
) (
  input  logic [AW-1:0] base_i,
  input  logic [OW-1:0] off_i,
  input  logic          take_i,
  output logic [AW-1:0] pc_o
);
  localparam int unsigned EXT_W = AW - OW;

  logic [AW-1:0] off_ext;
  logic [AW-1:0] sum;

  assign off_ext = {{EXT_W{off_i[OW-1]}}, off_i};
  assign sum     = base_i + off_ext;  // wraps modulo 2^AW
  assign pc_o    = take_i ? sum : base_i;
endmodule

// File: rtl/rel_branch_unit.sv
module rel_branch_unit
  import rbu_pkg::*;
#(
  parameter int unsigned AW          = 16,
  parameter int unsigned OW          = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          REG_OUT     = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CSEL_W-1:0] cond_sel_i,
  input  logic              carry_i,
  input  logic              zero_i,
  input  logic              neg_i,
  input  logic              half_i,
  input  logic              imask_i,
  input  logic              irq_pin_i,
  input  logic [AW-1:0]     next_pc_i,
  input  logic [OW-1:0]     offset_i,
  output logic              taken_o,
  output logic [AW-1:0]     target_o
);
  flags_t        flags;
  logic          pin_sync;
  logic          take_c;
  logic [AW-1:0] pc_c;

  assign flags = '{c: carry_i, z: zero_i, n: neg_i, h: half_i, i: imask_i};

  rbu_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_pin_i),
    .q_o   (pin_sync)
  );

  rbu_cond u_cond (
    .sel_i  (cond_sel_i),
    .flags_i(flags),
    .pin_i  (pin_sync),
    .take_o (take_c)
  );

  rbu_target #(.AW(AW), .OW(OW)) u_target (
    .base_i(next_pc_i),
    .off_i (offset_i),
    .take_i(take_c),
    .pc_o  (pc_c)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        taken_o  <= 1'b0;
        target_o <= '0;
      end else begin
        taken_o  <= take_c;
        target_o <= pc_c;
      end
    end
  end else begin : g_comb
    assign taken_o  = take_c;
    assign target_o = pc_c;
  end
endmodule

// File: rtl/rbu_checker.sv
module rbu_checker
  import rbu_pkg::*;
#(
  parameter int unsigned AW      = 16,
  parameter int unsigned OW      = 8,
  parameter bit          REG_OUT = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CSEL_W-1:0] cond_sel_i,
  input logic              carry_i,
  input logic              zero_i,
  input logic [AW-1:0]     next_pc_i,
  input logic [OW-1:0]     offset_i,
  input logic              taken_o,
  input logic [AW-1:0]     target_o
);
  logic [CSEL_W-1:0] d_sel;
  logic              d_c, d_z, armed;
  logic [AW-1:0]     d_next;
  logic [OW-1:0]     d_off;
  logic [AW-1:0]     d_sum;

  if (REG_OUT) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        d_sel <= '0; d_c <= 1'b0; d_z <= 1'b0;
        d_next <= '0; d_off <= '0; armed <= 1'b0;
      end else begin
        d_sel <= cond_sel_i; d_c <= carry_i; d_z <= zero_i;
        d_next <= next_pc_i; d_off <= offset_i; armed <= 1'b1;
      end
    end
  end else begin : g_now
    assign d_sel  = cond_sel_i;
    assign d_c    = carry_i;
    assign d_z    = zero_i;
    assign d_next = next_pc_i;
    assign d_off  = offset_i;
    assign armed  = 1'b1;
  end

  assign d_sum = d_next + AW'($signed(d_off));

  a_r1_taken_adds_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && taken_o) |-> (target_o == d_sum));
  a_r4_fall_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !taken_o) |-> (target_o == d_next));
  a_r12_never: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && d_sel == COND_NEVER) |-> !taken_o);
  a_r12_always: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && d_sel == COND_ALWAYS) |-> taken_o);
  a_r13_unused_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && d_sel > COND_LAST) |-> !taken_o);
  a_r5_hs_matches_cc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && (d_sel == COND_HS || d_sel == COND_CC)) |-> (taken_o == !d_c));
  a_r6_eq_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && d_sel == COND_EQ) |-> (taken_o == d_z));
endmodule

bind rel_branch_unit rbu_checker #(.AW(AW), .OW(OW), .REG_OUT(REG_OUT)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cond_sel_i(cond_sel_i),
  .carry_i   (carry_i),
  .zero_i    (zero_i),
  .next_pc_i (next_pc_i),
  .offset_i  (offset_i),
  .taken_o   (taken_o),
  .target_o  (target_o)
);

// File: tb/rel_branch_unit_test.sv
module rel_branch_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  sel = '0;
  logic        c = 0, z = 0, n = 0, h = 0, im = 0, pin = 1'b1;
  logic [15:0] npc = '0;
  logic [7:0]  off = '0;
  logic        tk, tk_r;
  logic [15:0] tg, tg_r;
  logic        m1, m2;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  rel_branch_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .cond_sel_i(sel), .carry_i(c), .zero_i(z),
    .neg_i(n), .half_i(h), .imask_i(im), .irq_pin_i(pin), .next_pc_i(npc),
    .offset_i(off), .taken_o(tk), .target_o(tg));

  rel_branch_unit #(.REG_OUT(1'b1)) uut_reg (
    .clk_i(clk), .rst_ni(rst_n), .cond_sel_i(sel), .carry_i(c), .zero_i(z),
    .neg_i(n), .half_i(h), .imask_i(im), .irq_pin_i(pin), .next_pc_i(npc),
    .offset_i(off), .taken_o(tk_r), .target_o(tg_r));

  // two-edge pin delay model, idle high
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin m1 <= 1'b1; m2 <= 1'b1; end
    else begin m1 <= pin; m2 <= m1; end

  function automatic logic exp_take(logic [4:0] s, logic pc, logic pz, logic pn,
                                    logic ph, logic pi, logic pp);
    case (s)
      5'd0: return 1'b0;      5'd1: return 1'b1;
      5'd2, 5'd10: return !pc;
      5'd3, 5'd11: return pc;
      5'd4: return !pz;       5'd5: return pz;
      5'd6: return !ph;       5'd7: return ph;
      5'd8: return !(pc | pz); 5'd9: return pc | pz;
      5'd12: return !pn;      5'd13: return pn;
      5'd14: return !pi;      5'd15: return pi;
      5'd16: return pp;       5'd17: return !pp;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(logic [4:0] s);
    case (s)
      5'd0, 5'd1: return "R12";
      5'd2, 5'd3, 5'd10, 5'd11: return "R5";
      5'd4, 5'd5: return "R6";
      5'd6, 5'd7: return "R9";
      5'd8, 5'd9: return "R7";
      5'd12, 5'd13: return "R8";
      5'd14, 5'd15: return "R10";
      5'd16, 5'd17: return "R11";
      default: return "R13";
    endcase
  endfunction

  function automatic logic [15:0] exp_pc(logic t, logic [15:0] b, logic [7:0] o);
    return t ? b + {{8{o[7]}}, o} : b;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, check comb instance, then registered instance
  task automatic apply(logic [4:0] s, logic [4:0] f, logic p, logic [15:0] b,
                       logic [7:0] o, string rq);
    logic et;
    logic [15:0] ep;
    @(negedge clk);
    sel = s; {c, z, n, h, im} = f; pin = p; npc = b; off = o;
    #1;
    et = exp_take(s, c, z, n, h, im, m2);
    ep = exp_pc(et, b, o);
    chk(rq, {31'd0, tk}, {31'd0, et});
    chk(et ? rq : "R4", {16'd0, tg}, {16'd0, ep});
    @(posedge clk); #1;
    chk("R14", {15'd0, tk_r, tg_r}, {15'd0, et, ep});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    // reset state: sync idles high, registered outputs zero
    sel = 5'd16; npc = 16'h1000; off = 8'h10;
    #12;
    chk("R11", {31'd0, tk}, 32'd1);
    chk("R14", {15'd0, tk_r, tg_r}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R1 R2 reach at both ends of offset range
    apply(5'd1, 5'd0, 1'b1, 16'h1000, 8'h80, "R1");
    chk("R1", {16'd0, tg}, 32'h0F80);
    apply(5'd1, 5'd0, 1'b1, 16'h1000, 8'h7F, "R1");
    chk("R2", {16'd0, tg}, 32'h107F);
    apply(5'd1, 5'd0, 1'b1, 16'h2002, 8'h00, "R2");
    // R3 wrap both ways
    apply(5'd1, 5'd0, 1'b1, 16'hFFF0, 8'h7F, "R3");
    chk("R3", {16'd0, tg}, 32'h006F);
    apply(5'd1, 5'd0, 1'b1, 16'h0010, 8'h80, "R3");
    chk("R3", {16'd0, tg}, 32'hFF90);
    // R4 not taken keeps follow-on address
    apply(5'd0, 5'h1F, 1'b1, 16'hFFF0, 8'h7F, "R4");
    chk("R4", {16'd0, tg}, 32'hFFF0);

    // R11 pin edge seen after two edges
    @(negedge clk); sel = 5'd17; pin = 1'b0;
    @(negedge clk); #1 chk("R11", {31'd0, tk}, 32'd0);
    @(negedge clk); #1 chk("R11", {31'd0, tk}, 32'd1);

    // every code, all flag combos, both pin levels
    for (int p = 0; p < 2; p++) begin
      @(negedge clk); pin = p[0];
      repeat (3) @(negedge clk);
      for (int s = 0; s < 32; s++)
        for (int f = 0; f < 32; f++)
          apply(s[4:0], f[4:0], p[0], 16'h4000 + 16'(s), 8'(f * 7), req_of(s[4:0]));
    end

    // random mix
    for (int k = 0; k < 2000; k++) begin
      logic [4:0] rs;
      rs = 5'($urandom_range(0, 31));
      apply(rs, 5'($urandom), 1'($urandom), 16'($urandom), 8'($urandom), req_of(rs));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule